// File: doc/BRIEF.md
# Task Register Load Unit

This unit carries out the load-task-register operation of a segmented processor. It accepts a 16-bit selector and the current privilege level. It then fetches the 8-byte system descriptor that the selector picks from a global descriptor table in memory.

The unit validates the fetched entry as an available task-state segment. If the entry passes, the unit sets the entry's busy type in memory and loads the task register:
- the visible selector;
- the hidden base, limit and access byte.

Every failed check finishes the operation with a fault vector and an error code. A failed check changes neither the register nor memory.

The execution pipeline starts the unit with a one-cycle `start` pulse and then waits for the `done` pulse. The memory side is a single 32-bit word port with a request/acknowledge handshake. The table base and the table limit come from the surrounding descriptor-table register.

Top module: `task_reg_loader`

## Requirements
- R1: When the privilege level `cpl` is not 0, the unit ends with `fault`=1, vector 13 and error code 0. It makes no memory access.
- R2: When `cpl` is 0 and selector bit 2 (table indicator) is 1, the unit ends with vector 13 and error code `{selector[15:2],2'b00}`. It makes no memory access.
- R3: When `cpl` is 0 and `selector[15:2]` is 0 (null selector), the unit ends with vector 13 and the same error code. It makes no memory access.
- R4: The index is `selector[15:3]`. When `index*8+7` exceeds `tableLimit` (byte limit, inclusive), the unit ends with vector 13 and the same error code. It makes no memory access.
- R5: A selector that passes the checks causes two reads: first the low word at `tableBase+index*8`, then the high word at that address plus 4.
- R6: The access byte is high-word bits 15:8. Bit 15 is present, bit 12 is the descriptor kind and bits 11:8 are the type. Unless present=1, kind=0 and type=9, the unit ends with vector 10 and error code `{selector[15:2],2'b00}`. It makes no write.
- R7: On success the unit writes the high word back to its own address with type 11 (bit 9 set). All other bits are unchanged. This write is the only one.
- R8: On success the task register is loaded as follows:
  - `trSel` takes the selector.
  - `trBase` is `{hi[31:24],hi[7:0],lo[31:16]}`.
  - `trAccess` is the access byte as written back (type 11).
  - `done` pulses with `fault`=0.
- R9: The raw 20-bit limit is `{hi[19:16],lo[15:0]}`. `trLimit` is the raw limit when bit 23 of the high word (granularity) is 0. When that bit is 1, `trLimit` is `raw*4096+4095`.
- R10: A faulting load leaves `trSel`, `trBase`, `trLimit` and `trAccess` unchanged and finishes with a one-cycle `done` together with `fault`=1.
- R11: Checks have priority in this order: privilege first, then the selector checks, then the descriptor checks.
- R12: After reset the following are 0: `trSel`, `trBase`, `trLimit`, `trAccess`, `done` and `memReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| selector | input | 16 | Selector operand |
| cpl | input | 2 | Current privilege level |
| tableBase | input | ADDR_W | Byte address of the global table |
| tableLimit | input | 16 | Inclusive byte limit of the global table |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory write enable |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with `memAck` |
| memAck | input | 1 | Memory acknowledge |
| done | output | 1 | Operation finished (one cycle) |
| fault | output | 1 | Operation ended in a fault |
| faultVec | output | 8 | Fault vector number |
| faultCode | output | 16 | Fault error code |
| trSel | output | 16 | Visible task-register selector |
| trBase | output | 32 | Hidden segment base |
| trLimit | output | 32 | Hidden segment limit in bytes |
| trAccess | output | 8 | Hidden access byte |

## Verification
The bench builds the unit with its defaults: a 32-bit address and a 4 KiB granularity shift. It places an eight-entry table at byte 0x20 with limit 0x3F, so indices 8 and 9 land just past the inclusive limit and index 7 sits exactly on it.

The first sweep covers every combination of these inputs:
- the indices 0 to 9;
- both table-indicator values;
- all four requested-privilege bit values;
- privilege levels 0 and 2.

This reaches the null, indicator, limit and privilege faults and their order of priority.

A second sweep on one entry varies all sixteen types together with the present, kind and granularity bits. This reaches every descriptor-fault case and both limit scalings.

// File: rtl/trl_pkg.sv
package trl_pkg;
  localparam logic [7:0] VEC_GP     = 8'd13;
  localparam logic [7:0] VEC_TS     = 8'd10;
  localparam logic [3:0] TYPE_AVAIL = 4'd9;
  localparam logic [3:0] TYPE_BUSY  = 4'd11;

  typedef struct packed {
    logic capReq;
    logic capLo;
    logic capHi;
    logic faultPriv;
    logic faultSel;
    logic faultDesc;
    logic commit;
    logic memReq;
    logic memWe;
    logic memHi;
  } trlStrobe_t;
endpackage

// File: rtl/trl_ctrl.sv
module trl_ctrl
  import trl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memAck,
  input  logic       privBad,
  input  logic       selBad,
  input  logic       descBad,
  output trlStrobe_t str
);
  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RLO, S_RHI, S_VAL, S_WHI} state_t;
  state_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    str = '0;
    nxt = state;
    unique case (state)
      S_IDLE: if (start) begin str.capReq = 1'b1; nxt = S_CHK; end
      S_CHK: begin
        // privilege outranks selector checks (R11)
        if (privBad)     begin str.faultPriv = 1'b1; nxt = S_IDLE; end
        else if (selBad) begin str.faultSel  = 1'b1; nxt = S_IDLE; end
        else nxt = S_RLO;
      end
      S_RLO: begin
        str.memReq = 1'b1;
        if (memAck) begin str.capLo = 1'b1; nxt = S_RHI; end
      end
      S_RHI: begin
        str.memReq = 1'b1;
        str.memHi  = 1'b1;
        if (memAck) begin str.capHi = 1'b1; nxt = S_VAL; end
      end
      S_VAL: begin
        if (descBad) begin str.faultDesc = 1'b1; nxt = S_IDLE; end
        else nxt = S_WHI;
      end
      S_WHI: begin
        str.memReq = 1'b1;
        str.memWe  = 1'b1;
        str.memHi  = 1'b1;
        if (memAck) begin str.commit = 1'b1; nxt = S_IDLE; end
      end
      default: nxt = S_IDLE;
    endcase
  end

  // R10: exactly one way to finish an operation
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.faultPriv, str.faultSel, str.faultDesc, str.commit}));

  // R5: a pending request holds its kind until acknowledged
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (str.memReq && !memAck) |=> (str.memReq && $stable(str.memWe) && $stable(str.memHi)));
endmodule

// File: rtl/trl_dpath.sv
module trl_dpath
  import trl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAN_SHIFT = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  trlStrobe_t        str,
  input  logic [15:0]       selector,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [15:0]       tableLimit,
  input  logic [31:0]       memRdata,
  output logic              privBad,
  output logic              selBad,
  output logic              descBad,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              done,
  output logic              fault,
  output logic [7:0]        faultVec,
  output logic [15:0]       faultCode,
  output logic [15:0]       trSel,
  output logic [31:0]       trBase,
  output logic [31:0]       trLimit,
  output logic [7:0]        trAccess
);
  localparam logic [31:0] GRAN_FILL = (32'd1 << GRAN_SHIFT) - 32'd1;

  logic [15:0] selQ;
  logic [1:0]  cplQ;
  logic [31:0] loQ, hiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0; cplQ <= '0; loQ <= '0; hiQ <= '0;
    end else begin
      if (str.capReq) begin selQ <= selector; cplQ <= cpl; end
      if (str.capLo) loQ <= memRdata;
      if (str.capHi) hiQ <= memRdata;
    end
  end

  logic [12:0] idx;
  logic [15:0] errCode;
  logic [7:0]  access, busyAccess;
  logic [19:0] rawLim;
  logic [31:0] descLimit, descBase;
  logic [ADDR_W-1:0] descAddr;

  assign idx      = selQ[15:3];
  assign errCode  = {selQ[15:2], 2'b00};
  assign privBad  = (cplQ != 2'd0);
  assign selBad   = selQ[2] || (selQ[15:2] == 14'd0) || ({idx, 3'b111} > tableLimit);
  assign descAddr = tableBase + ADDR_W'({idx, 3'b000});
  assign memAddr  = str.memHi ? descAddr + ADDR_W'(4) : descAddr;

  assign access     = hiQ[15:8];
  assign descBad    = !access[7] || access[4] || (access[3:0] != TYPE_AVAIL);
  assign busyAccess = {access[7:4], TYPE_BUSY};
  assign memWdata   = {hiQ[31:16], busyAccess, hiQ[7:0]};

  assign rawLim    = {hiQ[19:16], loQ[15:0]};
  assign descBase  = {hiQ[31:24], hiQ[7:0], loQ[31:16]};
  assign descLimit = hiQ[23] ? ((32'(rawLim) << GRAN_SHIFT) | GRAN_FILL) : 32'(rawLim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= 1'b0; fault <= 1'b0; faultVec <= '0; faultCode <= '0;
      trSel <= '0; trBase <= '0; trLimit <= '0; trAccess <= '0;
    end else begin
      done  <= str.faultPriv | str.faultSel | str.faultDesc | str.commit;
      fault <= str.faultPriv | str.faultSel | str.faultDesc;
      if (str.faultPriv) begin faultVec <= VEC_GP; faultCode <= 16'd0;  end
      if (str.faultSel)  begin faultVec <= VEC_GP; faultCode <= errCode; end
      if (str.faultDesc) begin faultVec <= VEC_TS; faultCode <= errCode; end
      if (str.commit) begin
        faultVec <= '0; faultCode <= '0;
        trSel <= selQ; trBase <= descBase; trLimit <= descLimit; trAccess <= busyAccess;
      end
    end
  end

  a_r1_priv_code: assert property (@(posedge clk) disable iff (!rstN)
    str.faultPriv |=> (done && fault && faultVec == VEC_GP && faultCode == 16'd0));

  a_r7_busy_write: assert property (@(posedge clk) disable iff (!rstN)
    str.memWe |-> (memWdata[11:8] == TYPE_BUSY && memWdata[15] && !memWdata[12]));

  a_r10_fault_keeps_tr: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> ($stable(trSel) && $stable(trBase) && $stable(trLimit) && $stable(trAccess)));

  a_r8_commit_loads: assert property (@(posedge clk) disable iff (!rstN)
    str.commit |=> (done && !fault && trSel == $past(selQ)));
endmodule

// File: rtl/task_reg_loader.sv
module task_reg_loader
  import trl_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAN_SHIFT = 12
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       selector,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [15:0]       tableLimit,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              done,
  output logic              fault,
  output logic [7:0]        faultVec,
  output logic [15:0]       faultCode,
  output logic [15:0]       trSel,
  output logic [31:0]       trBase,
  output logic [31:0]       trLimit,
  output logic [7:0]        trAccess
);
  trlStrobe_t str;
  logic privBad, selBad, descBad;

  trl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .memAck(memAck),
    .privBad(privBad), .selBad(selBad), .descBad(descBad), .str(str)
  );

  trl_dpath #(.ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT)) u_dpath (
    .clk(clk), .rstN(rstN), .str(str), .selector(selector), .cpl(cpl),
    .tableBase(tableBase), .tableLimit(tableLimit), .memRdata(memRdata),
    .privBad(privBad), .selBad(selBad), .descBad(descBad),
    .memAddr(memAddr), .memWdata(memWdata), .done(done), .fault(fault),
    .faultVec(faultVec), .faultCode(faultCode), .trSel(trSel), .trBase(trBase),
    .trLimit(trLimit), .trAccess(trAccess)
  );

  assign memReq = str.memReq;
  assign memWe  = str.memWe;
endmodule

// File: tb/task_reg_loader_tb.sv
module task_reg_loader_tb;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rstN = 0, start = 0;
  logic [15:0] selector = 0;
  logic [1:0]  cpl = 0;
  logic [31:0] tableBase = 32'h20;
  logic [15:0] tableLimit = 16'h3F;
  logic        memReq, memWe, memAck = 0;
  logic [31:0] memAddr, memWdata, memRdata = 0;
  logic        done, fault;
  logic [7:0]  faultVec, trAccess;
  logic [15:0] faultCode, trSel;
  logic [31:0] trBase, trLimit;

  task_reg_loader u_dut (
    .clk(clk), .rstN(rstN), .start(start), .selector(selector), .cpl(cpl),
    .tableBase(tableBase), .tableLimit(tableLimit), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .done(done), .fault(fault), .faultVec(faultVec), .faultCode(faultCode),
    .trSel(trSel), .trBase(trBase), .trLimit(trLimit), .trAccess(trAccess)
  );

  logic [31:0] mem [64];
  int accCount = 0, wrCount = 0, total = 0, fails = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      accCount <= accCount + 1;
      if (memWe) begin mem[memAddr[7:2]] <= memWdata; wrCount <= wrCount + 1; end
      memRdata <= mem[memAddr[7:2]];
    end else memAck <= 1'b0;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] baseOf(int i);
    return {8'(i + 1), 8'hA5, 8'(i * 3), 8'h5A};
  endfunction
  function automatic logic [19:0] limOf(int i);
    return {4'(i), 16'h1000 + 16'(i)};
  endfunction
  function automatic logic [31:0] hiOf(int i, logic [7:0] acc, logic g);
    logic [31:0] b = baseOf(i); logic [19:0] l = limOf(i);
    return {b[31:24], g, 3'b000, l[19:16], acc, b[23:16]};
  endfunction

  task automatic initDescs();
    for (int i = 0; i < 10; i++) begin
      mem[8 + 2 * i] = {baseOf(i)[15:0], limOf(i)[15:0]};
      mem[9 + 2 * i] = hiOf(i, 8'h89, 1'(i % 2));
    end
  endtask

  logic [15:0] eSel = 0;
  logic [31:0] eBase = 0, eLim = 0;
  logic [7:0]  eAcc = 0;

  task automatic doLoad(input logic [15:0] s, input logic [1:0] c);
    int i = int'(s[15:3]);
    logic [31:0] hiB = (i < 10) ? mem[9 + 2 * i] : 32'h0;
    logic [31:0] loB = (i < 10) ? mem[8 + 2 * i] : 32'h0;
    logic [7:0] acc = hiB[15:8];
    int kind; string tag;
    int waitN = 0;
    logic [15:0] code = {s[15:2], 2'b00};
    bit selWrong = s[2] || (s[15:2] == 0) || ((i * 8 + 7) > int'(tableLimit));
    if (c != 0) begin kind = 1; tag = selWrong ? "R11" : "R1"; end
    else if (s[2]) begin kind = 2; tag = "R2"; end
    else if (s[15:2] == 0) begin kind = 2; tag = "R3"; end
    else if (selWrong) begin kind = 2; tag = "R4"; end
    else if (!acc[7] || acc[4] || acc[3:0] != 4'd9) begin kind = 3; tag = "R6"; end
    else begin kind = 0; tag = hiB[23] ? "R9" : "R8"; end
    @(negedge clk);
    accCount = 0; wrCount = 0;
    selector = s; cpl = c; start = 1;
    @(negedge clk);
    start = 0;
    while (!done && waitN < 100) begin @(negedge clk); waitN++; end
    chk(tag, "done", 32'(done), 32'd1);
    chk(tag, "fault", 32'(fault), 32'(kind != 0));
    if (kind != 0) begin
      chk(tag, "faultVec", 32'(faultVec), (kind == 3) ? 32'd10 : 32'd13);
      chk(tag, "faultCode", 32'(faultCode), (kind == 1) ? 32'd0 : 32'(code));
      chk(kind == 3 ? "R6" : tag, "accesses", accCount, (kind == 3) ? 32'd2 : 32'd0);
      chk("R10", "writes", wrCount, 0);
      chk("R10", "trSel kept", 32'(trSel), 32'(eSel));
      chk("R10", "trBase kept", trBase, eBase);
      chk("R10", "trLimit kept", trLimit, eLim);
      chk("R10", "trAccess kept", 32'(trAccess), 32'(eAcc));
      if (i < 10) chk("R10", "desc untouched", mem[9 + 2 * i], hiB);
    end else begin
      logic [19:0] rl = {hiB[19:16], loB[15:0]};
      eSel = s;
      eBase = {hiB[31:24], hiB[7:0], loB[31:16]};
      eLim = hiB[23] ? (32'(rl) * 4096 + 4095) : 32'(rl);
      eAcc = acc | 8'h02;
      chk("R5", "accesses", accCount, 3);
      chk("R7", "writes", wrCount, 1);
      chk("R7", "busy hi word", mem[9 + 2 * i], hiB | 32'h200);
      chk("R7", "lo untouched", mem[8 + 2 * i], loB);
      chk("R8", "trSel", 32'(trSel), 32'(eSel));
      chk("R8", "trBase", trBase, eBase);
      chk(tag, "trLimit", trLimit, eLim);
      chk("R8", "trAccess", 32'(trAccess), 32'(eAcc));
    end
    @(negedge clk);
    chk("R10", "done pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'hDEAD_0000 + 32'(k);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R12", "trSel", 32'(trSel), 0);
    chk("R12", "trBase", trBase, 0);
    chk("R12", "trLimit", trLimit, 0);
    chk("R12", "trAccess", 32'(trAccess), 0);
    chk("R12", "done", 32'(done), 0);
    chk("R12", "memReq", 32'(memReq), 0);
    // selector and privilege sweep
    for (int i = 0; i < 10; i++)
      for (int ti = 0; ti < 2; ti++)
        for (int r = 0; r < 4; r++)
          for (int cc = 0; cc < 2; cc++) begin
            initDescs();
            doLoad({13'(i), 1'(ti), 2'(r)}, cc ? 2'd2 : 2'd0);
          end
    // descriptor attribute sweep on entry 2
    for (int t = 0; t < 16; t++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < 2; g++) begin
            initDescs();
            mem[13] = hiOf(2, {1'(p), 2'b00, 1'(s), 4'(t)}, 1'(g));
            doLoad(16'h0010, 2'd0);
          end
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule